// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a byte-organized serial EEPROM. It takes SCL and SDA levels that have already been synchronized to the system clock and filtered. It finds START and STOP conditions, shifts bits into bytes and answers each received byte with an acknowledge. It can also refuse a byte by leaving SDA high. It drives SDA only by pulling it low, through an open-drain enable.

A transfer begins with a device-select byte. That byte holds a fixed 1010 code, two bits that must match the strap inputs, the top address bit and the read/write bit. Two address bytes follow. Write data is collected in a page buffer indexed by the low address bits. A STOP then copies the collected bytes into the internal array during a timed write cycle. While that cycle runs, the block does not acknowledge any device select, which lets the master poll for completion. Reads stream bytes from the array and advance the address after each byte. A write-protect input that is held high refuses all data bytes.

The array depth is 2^AW bytes. A full-size part uses AW = 17, and the default is kept small. The page is 2^PW bytes. The write cycle length is WR_CYCLES clocks, which must be at least 2^PW + 1.

Top module: `eep_i2c_target`

## Requirements
- R1: A START seen in any state, including a repeated START, restarts device-select reception. A STOP always releases SDA and returns the block to idle.
- R2: In the device-select byte, bits 7..4 must be 1010 and bits 3..2 must equal strap_i[1:0]. A matching byte is acknowledged by pulling SDA low for the ninth clock. On a mismatch SDA stays released, and every later byte up to the next START is refused.
- R3: After a write select, two address bytes are acknowledged, the high byte first. Bit 1 of the select byte is address bit 16. The array uses the low AW bits of this 17-bit address.
- R4: Each acknowledged write data byte goes into the page buffer at the current in-page offset. The offset then increments and wraps within the same 2^PW page. A later byte at the same offset replaces the earlier one.
- R5: A STOP after at least one acknowledged data byte starts a write cycle of WR_CYCLES clocks. The cycle copies into the array only the buffered bytes. A STOP with no data byte starts no cycle.
- R6: While a write cycle runs, a device-select byte is not acknowledged and SDA is never pulled low.
- R7: While wp_i is high, data bytes are not acknowledged and no write cycle starts. The array keeps its earlier contents.
- R8: In a read, data is sent MSB first, and each bit is changed after SCL falls. The address increments after each byte and wraps from the top of the array to 0. An ACK from the master continues the read. A NACK releases SDA and ends it.
- R9: After reset, SDA is released and the block is idle and not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (wired bus value) |
| strap_i | input | 2 | Device select strap value |
| wp_i | input | 1 | Write protect, high blocks writes |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions check on every cycle that SDA stays released while a write cycle runs and after any STOP. They also check that an acknowledge of a select byte follows only a matching code and strap, and that no data byte is acknowledged with write protect high. A write cycle may start only with buffered data, and its timer stays inside its bound. Only the bench scenarios can show that data really reaches the array at the right place: page wrap and overwrite, the array-top wrap on reads, the effect of a STOP with no data, and that protected writes leave memory unchanged. The bench shows this by reading the array back.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam logic [3:0] SEL_CODE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_AHI,
        S_AHI_ACK,
        S_ALO,
        S_ALO_ACK,
        S_WR,
        S_WR_ACK,
        S_RD,
        S_RD_ACK
    } eep_state_e;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    typedef struct packed {
        logic scl;
        logic sda;
    } cond_t;

    cond_t q, d;

    always_comb begin
        d     = q;
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{scl: 1'b1, sda: 1'b1};
        else        q <= d;
    end

    assign scl_rise = scl_i & ~q.scl;
    assign scl_fall = ~scl_i & q.scl;
    assign start_p  = scl_i & q.scl & q.sda & ~sda_i;
    assign stop_p   = scl_i & q.scl & ~q.sda & sda_i;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int AW        = 11,
    parameter int PW        = 8,
    parameter int WR_CYCLES = 500000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                buf_we,
    input  logic [PW-1:0]       buf_off,
    input  logic [7:0]          buf_wdata,
    input  logic                buf_clear,
    input  logic                commit_go,
    input  logic [AW-PW-1:0]    page_base,
    input  logic [AW-1:0]       rd_addr,
    output logic [7:0]          rd_data,
    output logic                busy
);
    localparam int DEPTH  = 1 << AW;
    localparam int PAGE   = 1 << PW;
    localparam int BASE_W = AW - PW;
    localparam int TW     = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        logic              busy;
        logic [TW-1:0]     timer;
        logic [PW:0]       idx;
        logic [BASE_W-1:0] base;
        logic [PAGE-1:0]   valid;
    } store_t;

    store_t q, d;
    logic [7:0] pbuf [PAGE];
    logic [7:0] mem  [DEPTH];
    logic       copy_en;

    assign copy_en = q.busy && !q.idx[PW] && q.valid[q.idx[PW-1:0]];

    always_comb begin
        d = q;
        if (q.busy) begin
            if (!q.idx[PW]) d.idx = q.idx + 1'b1;
            if (q.timer == TW'(WR_CYCLES - 1)) begin
                d.busy  = 1'b0;
                d.valid = '0;
            end else begin
                d.timer = q.timer + 1'b1;
            end
        end else if (commit_go) begin
            d.busy  = 1'b1;
            d.timer = '0;
            d.idx   = '0;
            d.base  = page_base;
        end else begin
            if (buf_clear) d.valid = '0;
            if (buf_we)    d.valid[buf_off] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (buf_we && !q.busy) pbuf[buf_off] <= buf_wdata;
        if (copy_en) mem[{q.base, q.idx[PW-1:0]}] <= pbuf[q.idx[PW-1:0]];
    end

    assign rd_data = mem[rd_addr];
    assign busy    = q.busy;

    // R5: a write cycle only begins with at least one buffered byte
    a_r5_commit_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> (q.valid != '0));

    // R5: the write cycle timer never passes its bound
    a_r5_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.timer < TW'(WR_CYCLES)));
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target #(
    parameter int AW        = 11,
    parameter int PW        = 8,
    parameter int WR_CYCLES = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    input  logic       wp_i,
    output logic       sda_pull_o
);
    import eep_pkg::*;

    typedef struct packed {
        eep_state_e  st;
        logic [3:0]  bitcnt;
        logic [7:0]  sr;
        logic [7:0]  tx;
        logic [AW-1:0] addr;
        logic [7:0]  ahi;
        logic        a16;
        logic        rw;
        logic        mack;
        logic        sda_low;
        logic        have_data;
    } ctl_t;

    ctl_t q, d;

    logic scl_rise, scl_fall, start_p, stop_p;
    logic buf_we, buf_clear, commit_go, busy;
    logic [7:0] rd_data;

    eep_bus_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    eep_store #(.AW(AW), .PW(PW), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_we    (buf_we),
        .buf_off   (q.addr[PW-1:0]),
        .buf_wdata (q.sr),
        .buf_clear (buf_clear),
        .commit_go (commit_go),
        .page_base (q.addr[AW-1:PW]),
        .rd_addr   (q.addr),
        .rd_data   (rd_data),
        .busy      (busy)
    );

    always_comb begin
        d         = q;
        buf_we    = 1'b0;
        buf_clear = 1'b0;
        commit_go = 1'b0;
        if (start_p) begin
            d.st        = S_DEV;
            d.bitcnt    = '0;
            d.sda_low   = 1'b0;
            d.have_data = 1'b0;
            buf_clear   = 1'b1;
        end else if (stop_p) begin
            d.st        = S_IDLE;
            d.sda_low   = 1'b0;
            d.have_data = 1'b0;
            commit_go   = q.have_data && !wp_i && !busy;
        end else begin
            unique case (q.st)
                S_DEV, S_AHI, S_ALO, S_WR: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        d.sr     = {q.sr[6:0], sda_i};
                        d.bitcnt = q.bitcnt + 1'b1;
                    end
                    if (scl_fall && q.bitcnt == 4'd8) begin
                        d.bitcnt  = '0;
                        d.sda_low = 1'b1;
                        unique case (q.st)
                            S_DEV: begin
                                if (q.sr[7:4] == SEL_CODE && q.sr[3:2] == strap_i && !busy) begin
                                    d.st  = S_DEV_ACK;
                                    d.rw  = q.sr[0];
                                    if (!q.sr[0]) d.a16 = q.sr[1];
                                end else begin
                                    d.st      = S_IDLE;
                                    d.sda_low = 1'b0;
                                end
                            end
                            S_AHI: begin
                                d.ahi = q.sr;
                                d.st  = S_AHI_ACK;
                            end
                            S_ALO: begin
                                d.addr = AW'({q.a16, q.ahi, q.sr});
                                d.st   = S_ALO_ACK;
                            end
                            default: begin
                                if (!wp_i) begin
                                    buf_we      = 1'b1;
                                    d.have_data = 1'b1;
                                    d.addr      = {q.addr[AW-1:PW], q.addr[PW-1:0] + 1'b1};
                                    d.st        = S_WR_ACK;
                                end else begin
                                    d.st      = S_IDLE;
                                    d.sda_low = 1'b0;
                                end
                            end
                        endcase
                    end
                end
                S_DEV_ACK, S_AHI_ACK, S_ALO_ACK, S_WR_ACK: begin
                    if (scl_fall) begin
                        d.sda_low = 1'b0;
                        d.bitcnt  = '0;
                        unique case (q.st)
                            S_DEV_ACK: begin
                                if (q.rw) begin
                                    d.st      = S_RD;
                                    d.tx      = rd_data;
                                    d.sda_low = ~rd_data[7];
                                end else begin
                                    d.st = S_AHI;
                                end
                            end
                            S_AHI_ACK: d.st = S_ALO;
                            default:   d.st = S_WR;
                        endcase
                    end
                end
                S_RD: begin
                    if (scl_rise) d.bitcnt = q.bitcnt + 1'b1;
                    if (scl_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            d.sda_low = 1'b0;
                            d.bitcnt  = '0;
                            d.addr    = q.addr + 1'b1;
                            d.st      = S_RD_ACK;
                        end else begin
                            d.tx      = {q.tx[6:0], 1'b0};
                            d.sda_low = ~q.tx[6];
                        end
                    end
                end
                S_RD_ACK: begin
                    if (scl_rise) d.mack = ~sda_i;
                    if (scl_fall) begin
                        if (q.mack) begin
                            d.st      = S_RD;
                            d.tx      = rd_data;
                            d.sda_low = ~rd_data[7];
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    assign sda_pull_o = q.sda_low;

    // R6: SDA is never pulled while a write cycle runs
    a_r6_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !q.sda_low);

    // R1: a STOP always leaves SDA released
    a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !q.sda_low);

    // R2: a select acknowledge only follows a matching code and strap
    a_r2_ack_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.sda_low) && q.st == S_DEV_ACK) |->
            (q.sr[7:4] == SEL_CODE && q.sr[3:2] == strap_i));

    // R7: a data byte is acknowledged only with write protect low
    a_r7_wp_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WR_ACK && $past(q.st) == S_WR) |-> $past(!wp_i));
endmodule

// File: tb/eep_i2c_target_tb.sv
module eep_i2c_target_tb;
    localparam int AW  = 11;
    localparam int PW  = 8;
    localparam int WRC = 400;
    localparam int Q   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       wp = 1'b0;
    logic       sda_pull;
    logic       sda_line;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string req;
        int    val;
    } exp_t;

    exp_t exp_q[$];
    int   got_q[$];

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    eep_i2c_target #(.AW(AW), .PW(PW), .WR_CYCLES(WRC)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .wp_i       (wp),
        .sda_pull_o (sda_pull)
    );

    // monitor: compares produced results against expected items in order
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                exp_t e;
                int   g;
                e = exp_q.pop_front();
                g = got_q.pop_front();
                checks++;
                if (g != e.val) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", e.req, g, e.val);
                end
            end
        end
    end

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(2 * Q);
        sda_m = 1'b0; waitq(2 * Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b1; waitq(2 * Q);
        sda_m = 1'b1; waitq(2 * Q);
    endtask

    task automatic bit_out(input logic b);
        waitq(Q); sda_m = b; waitq(Q);
        scl_m = 1'b1; waitq(2 * Q);
        scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        waitq(Q); sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        b = sda_line; waitq(Q);
        scl_m = 1'b0;
    endtask

    // sends a byte; pushes expected ack (1 = acknowledged) unless exp_ack < 0
    task automatic send(input logic [7:0] v, input int exp_ack, input string req);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        if (exp_ack >= 0) begin
            exp_q.push_back('{req, exp_ack});
            got_q.push_back(int'(!a));
        end
    endtask

    task automatic recv(input logic [7:0] exp_v, input logic more, input string req);
        logic [7:0] v;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(!more);
        exp_q.push_back('{req, int'(exp_v)});
        got_q.push_back(int'(v));
    endtask

    function automatic logic [7:0] sel(input logic rd);
        return {4'b1010, strap, 1'b0, rd};
    endfunction

    task automatic set_addr(input logic [15:0] a, input string req);
        bus_start();
        send(sel(1'b0), 1, req);
        send(a[15:8], 1, "R3 address high ack");
        send(a[7:0], 1, "R3 address low ack");
    endtask

    function automatic logic [7:0] pv(input int i);
        return 8'(i) ^ 8'h3C;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        waitq(5);
        rst_n = 1'b1;
        waitq(5);
        checks++;
        if (sda_pull !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset sda actual=%0b expected=0", sda_pull);
        end

        // R2: strap mismatch is refused and the rest is ignored
        bus_start();
        send({4'b1010, 2'b01, 1'b0, 1'b0}, 0, "R2 strap mismatch nack");
        send(8'h00, 0, "R2 later byte ignored");
        bus_stop();
        // R2: wrong fixed code
        bus_start();
        send({4'b1011, strap, 1'b0, 1'b0}, 0, "R2 bad code nack");
        bus_stop();

        // R4/R5: simple write of three bytes
        set_addr(16'h0123, "R2 select ack");
        send(8'hA0, 1, "R4 data ack");
        send(8'hA1, 1, "R4 data ack");
        send(8'hA2, 1, "R4 data ack");
        bus_stop();
        // R6: polling during the write cycle is refused
        bus_start();
        send(sel(1'b0), 0, "R6 busy select nack");
        bus_stop();
        waitq(WRC + 50);

        // R1/R8: random read through a repeated START
        set_addr(16'h0123, "R1 select ack");
        bus_start();
        send(sel(1'b1), 1, "R1 repeated start read select ack");
        recv(8'hA0, 1'b1, "R5 readback 0123");
        recv(8'hA1, 1'b1, "R8 sequential 0124");
        recv(8'hA2, 1'b0, "R8 sequential 0125");
        bus_stop();

        // R4: page wrap and overwrite with 258 bytes from offset FF
        set_addr(16'h05FF, "R2 select ack");
        for (int i = 0; i < 258; i++) send(pv(i), (i < 2 || i > 255) ? 1 : -1, "R4 page data ack");
        bus_stop();
        waitq(WRC + 50);
        set_addr(16'h05FE, "R3 select ack");
        bus_start();
        send(sel(1'b1), 1, "R8 read select ack");
        recv(pv(255), 1'b1, "R4 wrap offset FE");
        recv(pv(256), 1'b0, "R4 overwrite offset FF");
        bus_stop();
        set_addr(16'h0500, "R3 select ack");
        bus_start();
        send(sel(1'b1), 1, "R8 read select ack");
        recv(pv(257), 1'b1, "R4 wrapped overwrite offset 00");
        recv(pv(2), 1'b1, "R4 wrapped offset 01");
        recv(pv(3), 1'b0, "R4 wrapped offset 02");
        bus_stop();

        // R5: STOP with no data starts no cycle
        set_addr(16'h0040, "R3 select ack");
        bus_stop();
        bus_start();
        send(sel(1'b0), 1, "R5 no cycle after address-only write");
        bus_stop();

        // R7: write protect refuses data and leaves memory unchanged
        wp = 1'b1;
        set_addr(16'h0123, "R7 select ack");
        send(8'h77, 0, "R7 protected data nack");
        bus_stop();
        bus_start();
        send(sel(1'b0), 1, "R7 no cycle under protect");
        bus_stop();
        wp = 1'b0;
        set_addr(16'h0123, "R7 select ack");
        bus_start();
        send(sel(1'b1), 1, "R7 read select ack");
        recv(8'hA0, 1'b0, "R7 memory unchanged");
        bus_stop();

        // R8: read wraps at the array top
        set_addr(16'h0000, "R3 select ack");
        send(8'h5A, 1, "R4 data ack");
        bus_stop();
        waitq(WRC + 50);
        set_addr(16'h07FF, "R3 select ack");
        send(8'hEE, 1, "R4 data ack");
        bus_stop();
        waitq(WRC + 50);
        set_addr(16'h07FF, "R3 select ack");
        bus_start();
        send(sel(1'b1), 1, "R8 read select ack");
        recv(8'hEE, 1'b1, "R8 top byte");
        recv(8'h5A, 1'b0, "R8 wrap to zero");
        waitq(2);
        checks++;
        if (sda_pull !== 1'b0) begin
            errors++;
            $display("FAIL R8 sda after nack actual=%0b expected=0", sda_pull);
        end
        bus_stop();

        waitq(20);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1 unmatched items actual=%0d expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule